// File: doc/BRIEF.md
# Cycle-Stealing Data Break Controller

This block moves single data words between a peripheral and a single-port synchronous memory by stealing memory cycles from the processor. While it owns the memory it raises a stall line to the processor. Between separate requests the memory goes back to the processor. A device asks for one transfer at a time through a request line and gets a one-cycle grant pulse back.

There are two modes. In the memory-bookkeeping mode, the remaining-transfer count and the buffer pointer are kept in main memory. They sit at two neighbouring locations whose base address is a static input wired by the device. Each transfer then takes three memory cycles: count update, pointer update, data. In the device-bookkeeping mode the device keeps its own count and presents the address itself, so only the data cycle is spent. The transfer rate is three times higher in this mode.

Every memory cycle takes two clocks. An update cycle is a read followed by a write-back. A data cycle is an access clock followed by a completion clock.

Top module: `data_break_ctrl`

## Requirements
- R1: During and after reset, with no request, `mem_en`, `dev_grant`, `dev_rvalid` and `dev_done` are low and `cpu_stall` is low.
- R2: A request is accepted only when the block is idle. `dev_grant` is high for exactly the first clock after acceptance. A request held during a transfer is accepted again only after the transfer has finished.
- R3: With `dev_mode`=0, the six clocks after acceptance are, in order: read of the count at `dev_base`, write of the count to `dev_base`, read of the pointer at `dev_base`+1, write of the pointer, the data access, and an idle completion clock with `mem_en` low.
- R4: The stored count is the negative of the remaining transfers. It is written back as the read value plus one, modulo 2^DW.
- R5: `dev_done` pulses for one clock in the clock after the data cycle completes. It pulses only when `dev_mode`=0 and the written-back count is zero.
- R6: The pointer is written back as its low AW bits plus one, modulo 2^AW, zero-extended to DW bits. The incremented value is the data address.
- R7: With `dev_dir`=1 the data access writes the `dev_wdata` sampled at acceptance. With `dev_dir`=0 it reads, and `dev_rdata` carries the word together with a one-clock `dev_rvalid` in the clock after the completion clock.
- R8: With `dev_mode`=1, the first clock after acceptance is the data access at `dev_addr`, followed by one completion clock. No count or pointer location is touched.
- R9: `cpu_stall` is high in the cycle a request is accepted and in every stolen clock, including the completion clock. It is low in idle when no request is present.
- R10: The count location is `dev_base`, and the pointer location is `dev_base`+1 modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | 1 | Device transfer request |
| dev_mode | input | 1 | 0 = bookkeeping in memory (three cycles), 1 = device-held address (one cycle) |
| dev_dir | input | 1 | 1 = device word into memory, 0 = memory word to device |
| dev_base | input | AW | Static base of the count/pointer pair |
| dev_addr | input | AW | Data address for the single-cycle mode |
| dev_wdata | input | DW | Word to store, sampled at acceptance |
| dev_grant | output | 1 | One-clock acceptance pulse |
| dev_rdata | output | DW | Word read for the device |
| dev_rvalid | output | 1 | One-clock strobe for dev_rdata |
| dev_done | output | 1 | One-clock pulse when the count reaches zero |
| cpu_stall | output | 1 | Processor held off memory |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one clock after a read |

## Verification
The bench builds the block with DW=12 and AW=8, so the memory model holds only 256 words. With this narrow address, the pointer wrap from 0xFF to 0x00 can be reached, and so can a base of 0xFF, whose pointer location wraps to 0x00. The 12-bit count lets the bench cover the step from -1 to zero (done), the step from -2 (no done) and the step from zero to one. Back-to-back held requests, address changes on `dev_wdata` after acceptance, and both modes in both directions are compared clock by clock against a behavioural model.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WC_RD,
    ST_WC_WR,
    ST_PT_RD,
    ST_PT_WR,
    ST_DAT_A,
    ST_DAT_B
  } dbk_state_e;
endpackage

// File: rtl/dbk_fsm.sv
module dbk_fsm
  import dbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_req,
  input  logic       dev_mode,
  output dbk_state_e st,
  output logic       acc,
  output logic       fin
);
  // acceptance event: only an idle controller takes a request
  assign acc = (st == ST_IDLE) && dev_req;
  // last stolen clock
  assign fin = (st == ST_DAT_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:  if (acc) st <= dev_mode ? ST_DAT_A : ST_WC_RD;
        ST_WC_RD: st <= ST_WC_WR;
        ST_WC_WR: st <= ST_PT_RD;
        ST_PT_RD: st <= ST_PT_WR;
        ST_PT_WR: st <= ST_DAT_A;
        ST_DAT_A: st <= ST_DAT_B;
        ST_DAT_B: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R2: never leave idle without a request
  a_r2_leave_idle_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && $past(st) == ST_IDLE) |-> $past(dev_req));
endmodule

// File: rtl/dbk_datapath.sv
module dbk_datapath
  import dbk_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dbk_state_e    st,
  input  logic          acc,
  input  logic          fin,
  input  logic          dev_mode,
  input  logic          dev_dir,
  input  logic [AW-1:0] dev_base,
  input  logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          dev_grant,
  output logic [DW-1:0] dev_rdata,
  output logic          dev_rvalid,
  output logic          dev_done
);
  function automatic logic [DW-1:0] count_step(input logic [DW-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] v);
    return v + 1'b1;
  endfunction

  logic          mode_q, dir_q, last_q;
  logic [AW-1:0] base_q, ptr_q;
  logic [DW-1:0] wdata_q;

  logic [DW-1:0] cnt_next;
  logic [AW-1:0] ptr_next, ptr_loc;
  logic          data_cyc;

  assign cnt_next = count_step(mem_rdata);
  assign ptr_next = addr_step(mem_rdata[AW-1:0]);
  assign ptr_loc  = addr_step(base_q);
  assign data_cyc = (st == ST_DAT_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      dir_q      <= 1'b0;
      last_q     <= 1'b0;
      base_q     <= '0;
      ptr_q      <= '0;
      wdata_q    <= '0;
      dev_grant  <= 1'b0;
      dev_rdata  <= '0;
      dev_rvalid <= 1'b0;
      dev_done   <= 1'b0;
    end else begin
      dev_grant  <= acc;
      dev_rvalid <= fin && !dir_q;
      dev_done   <= fin && !mode_q && last_q;
      if (acc) begin
        mode_q  <= dev_mode;
        dir_q   <= dev_dir;
        base_q  <= dev_base;
        ptr_q   <= dev_addr;
        wdata_q <= dev_wdata;
        last_q  <= 1'b0;
      end
      if (st == ST_WC_WR) last_q <= (cnt_next == '0);
      if (st == ST_PT_WR) ptr_q  <= ptr_next;
      if (fin && !dir_q)  dev_rdata <= mem_rdata;
    end
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_WC_RD: begin mem_en = 1'b1; mem_addr = base_q; end
      ST_WC_WR: begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = base_q; mem_wdata = cnt_next; end
      ST_PT_RD: begin mem_en = 1'b1; mem_addr = ptr_loc; end
      ST_PT_WR: begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = ptr_loc; mem_wdata = DW'(ptr_next); end
      ST_DAT_A: begin mem_en = 1'b1; mem_we = dir_q; mem_addr = ptr_q; mem_wdata = wdata_q; end
      default: ;
    endcase
  end

  // R3: every bookkeeping write follows a read of the same location
  a_r3_rmw_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !data_cyc) |->
      ($past(mem_en) && !$past(mem_we) && mem_addr == $past(mem_addr)));
  // R6: the data address is the pointer value written one clock before
  a_r6_data_uses_new_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cyc && !mode_q) |-> (mem_addr == $past(mem_wdata[AW-1:0])));
  // R5: done only in memory-bookkeeping mode
  a_r5_done_mode: assert property (@(posedge clk) disable iff (!rst_n)
    dev_done |-> !mode_q);
  // R7: read strobe only after a read transfer's completion clock
  a_r7_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rvalid |-> $past(fin && !dir_q));
  // R8: single-cycle transfers only touch memory in the data clock
  a_r8_single_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mode_q && !$past(acc && !dev_mode)) |-> data_cyc);
  // R2: grant is a single pulse following acceptance
  a_r2_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dev_grant |-> ($past(acc) && $onehot0({dev_grant, dev_rvalid})));
endmodule

// File: rtl/data_break_ctrl.sv
module data_break_ctrl #(
  parameter int DW = 12,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_req,
  input  logic          dev_mode,
  input  logic          dev_dir,
  input  logic [AW-1:0] dev_base,
  input  logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] dev_wdata,
  output logic          dev_grant,
  output logic [DW-1:0] dev_rdata,
  output logic          dev_rvalid,
  output logic          dev_done,
  output logic          cpu_stall,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import dbk_pkg::*;

  dbk_state_e st;
  logic       acc, fin;

  dbk_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_req  (dev_req),
    .dev_mode (dev_mode),
    .st       (st),
    .acc      (acc),
    .fin      (fin)
  );

  dbk_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .acc        (acc),
    .fin        (fin),
    .dev_mode   (dev_mode),
    .dev_dir    (dev_dir),
    .dev_base   (dev_base),
    .dev_addr   (dev_addr),
    .dev_wdata  (dev_wdata),
    .mem_rdata  (mem_rdata),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .dev_grant  (dev_grant),
    .dev_rdata  (dev_rdata),
    .dev_rvalid (dev_rvalid),
    .dev_done   (dev_done)
  );

  // R9: processor held off from acceptance through the last stolen clock
  assign cpu_stall = acc || (st != ST_IDLE);

  // R9: the processor never shares a clock with a stolen access
  a_r9_stall_covers_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> cpu_stall);
  // R9: the completion clock is still stolen
  a_r9_stall_completion: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (cpu_stall && !mem_en));
endmodule

// File: tb/test_data_break_ctrl.sv
module test_data_break_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int AW = 8;
  localparam int MSZ = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dev_req = 1'b0, dev_mode = 1'b0, dev_dir = 1'b0;
  logic [AW-1:0] dev_base = '0, dev_addr = '0;
  logic [DW-1:0] dev_wdata = '0;
  logic          dev_grant, dev_rvalid, dev_done, cpu_stall, mem_en, mem_we;
  logic [DW-1:0] dev_rdata, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  data_break_ctrl #(.DW(DW), .AW(AW)) i_data_break_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_mode(dev_mode),
    .dev_dir(dev_dir), .dev_base(dev_base), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_grant(dev_grant), .dev_rdata(dev_rdata),
    .dev_rvalid(dev_rvalid), .dev_done(dev_done), .cpu_stall(cpu_stall),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory the design drives
  logic [DW-1:0] mem [MSZ];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  // behavioural reference: shadow memory and a queue of per-clock expectations
  typedef struct {
    bit idle_st; bit en; bit we; int addr; int wdata;
    bit grant; bit rvalid; bit done; int rdata;
  } exp_t;

  int   shadow [MSZ];
  exp_t q [$];
  exp_t cur;

  function automatic exp_t idle_e();
    exp_t e;
    e = '{idle_st: 1'b1, default: 0};
    return e;
  endfunction

  function automatic exp_t acc_e(bit we, int a, int wd);
    exp_t e;
    e = '{default: 0};
    e.en = 1'b1; e.we = we; e.addr = a; e.wdata = wd;
    return e;
  endfunction

  task automatic plan_transfer();
    exp_t e, post;
    int b, pa, p, wc, da, wd;
    b = int'(dev_base); wd = int'(dev_wdata);
    post = idle_e();
    if (!dev_mode) begin
      wc = (shadow[b] + 1) % 4096;          // R4 count step
      shadow[b] = wc;
      pa = (b + 1) % MSZ;                    // R10 pointer location
      p = ((shadow[pa] % MSZ) + 1) % MSZ;    // R6 pointer step
      shadow[pa] = p;
      da = p;
      e = acc_e(0, b, 0); e.grant = 1; q.push_back(e);
      q.push_back(acc_e(1, b, wc));
      q.push_back(acc_e(0, pa, 0));
      q.push_back(acc_e(1, pa, p));
      post.done = (wc == 0);
    end else begin
      da = int'(dev_addr);
    end
    e = acc_e(dev_dir, da, wd);
    if (dev_mode) e.grant = 1;
    q.push_back(e);
    e = '{default: 0};
    q.push_back(e);                          // completion clock
    if (dev_dir) shadow[da] = wd;
    else begin post.rvalid = 1; post.rdata = shadow[da]; end
    q.push_back(post);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = idle_e();
    end else begin
      if (cur.idle_st && dev_req) plan_transfer();
      if (q.size() > 0) cur = q.pop_front();
      else cur = idle_e();
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, expv);
    end
  endtask

  bit run_checks = 1'b0;
  always @(negedge clk) begin
    if (run_checks) begin
      bit st_exp;
      st_exp = cur.idle_st ? dev_req : 1'b1;
      chk(cpu_stall == st_exp, "R9 cpu_stall", cpu_stall, st_exp);
      chk(mem_en == cur.en, "R3 mem_en", mem_en, cur.en);
      if (cur.en) begin
        chk(mem_we == cur.we, "R7 mem_we", mem_we, cur.we);
        chk(int'(mem_addr) == cur.addr, "R3 mem_addr", mem_addr, cur.addr);
        if (cur.we) chk(int'(mem_wdata) == cur.wdata, "R4 mem_wdata", mem_wdata, cur.wdata);
      end
      chk(dev_grant == cur.grant, "R2 dev_grant", dev_grant, cur.grant);
      chk(dev_rvalid == cur.rvalid, "R7 dev_rvalid", dev_rvalid, cur.rvalid);
      if (cur.rvalid) chk(int'(dev_rdata) == cur.rdata, "R7 dev_rdata", dev_rdata, cur.rdata);
      chk(dev_done == cur.done, "R5 dev_done", dev_done, cur.done);
    end
  end

  task automatic poke(int a, int v);
    mem[a] = DW'(v);
    shadow[a] = v;
  endtask

  // one request; hold2 keeps the request up for a second acceptance
  task automatic xfer(bit m, bit d, int b, int a, int w, bit hold2);
    @(posedge clk); #1;
    dev_mode = m; dev_dir = d; dev_base = AW'(b); dev_addr = AW'(a);
    dev_wdata = DW'(w); dev_req = 1'b1;
    do begin @(posedge clk); #1; end while (!dev_grant);
    dev_wdata = ~DW'(w);                     // R7 sampled only at acceptance
    if (hold2) begin
      do begin @(posedge clk); #1; end while (!dev_grant);
    end
    dev_req = 1'b0;
    repeat (9) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < MSZ; i++) poke(i, (i * 37 + 5) % 4096);
    poke(8'h10, 12'hFFE); poke(8'h11, 8'h2F); poke(8'h31, 12'h5A5);
    poke(8'hFF, 12'h000); poke(8'h00, 8'hFF);
    poke(8'h20, 12'hFFE); poke(8'h21, 8'h40);
    run_checks = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset state observed by the per-clock compare, plus explicit check
    @(negedge clk);
    chk(!mem_en && !dev_grant && !cpu_stall, "R1 reset idle", mem_en, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    xfer(0, 1, 8'h10, 0, 12'h123, 0);        // write, count -2 -> -1
    chk(mem[8'h10] == 12'hFFF, "R4 count -2 step", mem[8'h10], 12'hFFF);
    chk(mem[8'h11] == 12'h030, "R6 pointer step", mem[8'h11], 12'h030);
    chk(mem[8'h30] == 12'h123, "R7 stored word", mem[8'h30], 12'h123);

    xfer(0, 0, 8'h10, 0, 0, 0);              // read, count -1 -> 0, done
    chk(mem[8'h10] == 12'h000, "R5 count reaches zero", mem[8'h10], 0);

    xfer(0, 0, 8'hFF, 0, 0, 0);              // R10 base wrap, R6 pointer wrap
    chk(mem[8'hFF] == 12'h001, "R4 count zero step", mem[8'hFF], 1);
    chk(mem[8'h00] == 12'h000, "R10 pointer location wraps", mem[8'h00], 0);

    xfer(1, 1, 0, 8'h80, 12'hABC, 0);        // R8 single write
    chk(mem[8'h80] == 12'hABC, "R8 single write", mem[8'h80], 12'hABC);
    xfer(1, 0, 0, 8'h31, 0, 0);              // R8 single read

    xfer(0, 1, 8'h20, 0, 12'h777, 1);        // R2 held request, two transfers
    chk(mem[8'h20] == 12'h000, "R2 second transfer done", mem[8'h20], 0);
    chk(mem[8'h21] == 12'h042, "R6 two pointer steps", mem[8'h21], 12'h042);

    for (int i = 0; i < MSZ; i++)
      if (int'(mem[i]) != shadow[i]) chk(0, "R8 memory image", mem[i], shadow[i]);
    chk(1, "R8 memory image", 0, 0);

    run_checks = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule